// File: doc/BRIEF.md
# Pulse-Aligned Channel Sequencer with Interrupt Controller

This block sits next to a free-running pulse generator that fires a laser. Its main job is to drive a 2-bit receive-channel select. The select can follow a programmed rotation of four entries, which moves on by one a fixed number of cycles before every pulse. It can instead hold one value chosen by software. The block also has two smaller jobs. It emits a one-cycle clear strobe ahead of each sequencer step, so downstream packing logic can drop stale samples. It gathers interrupts from the pulse and from both edges of an active-low over-temperature warning.

The pulse generator supplies its running counter, which counts 0 up to `period-1`, and its period. From these the block knows where the pulse falls. With a sync offset `off`, the sequencer step is taken on the edge after the counter equals `period-off`. The clear strobe is high for the cycle that follows the counter equal to `period-off-2`. A flat word-addressed register port (write strobe, 4-bit word index, 32-bit data, combinational read data) holds all control and status.

Word map, by index: 0 driver enable (bit 0); 1 warning status (bit 0 = 1 while the warning is active); 2 interrupt mask (bits 2:0, 1 = masked); 3 interrupt source (bits 2:0, write 1 to clear); 4 interrupt pending (bits 2:0, read source AND NOT mask, write 1 to clear the source bit); 5 sequencer control (bit 0 enable, bit 1 auto); 6 sync offset; 7 rotation entries; 8 manual select (bits 1:0).

Top module: `pulse_seq_ctrl`

## Requirements
- R1: After reset: the driver-enable output is 0, the channel select is 0 and the interrupt output is 0. The mask reads 7, the sync offset reads OFFSET_RST, and the source reads 0.
- R2: The driver-enable output follows bit 0 of the last write to word 0.
- R3: Word 5 bit 0 enables the sequencer and bit 1 selects auto mode. While the sequencer is disabled, the channel select is 0 and the rotation position returns to entry 0.
- R4: When the sequencer is enabled with bit 1 clear, the channel select equals bits [1:0] of word 8 directly.
- R5: In auto mode the channel select shows rotation entry i, which word 7 holds at bits [4i+1:4i]. The position moves to the next entry on the clock edge after `pulse_cnt == pulse_period - offset`, and goes from entry 3 back to entry 0.
- R6: The clear strobe is high for exactly the one cycle after `pulse_cnt == pulse_period - offset - 2`. It therefore rises two cycles before the sequencer step.
- R7: Source bit 0 is set in any cycle that `pulse_in` is high. Bit 1 is set on a falling edge of `otw_n` (warning entry), and bit 2 on a rising edge (warning exit). Set bits stay set until cleared.
- R8: Pending equals source AND NOT mask, and the interrupt output is the OR of the three pending bits. A masked event still sets its source bit.
- R9: Writing 1 to a bit of word 3 or word 4 clears that source bit. Writing 0 leaves it unchanged.
- R10: Word 1 bit 0 reads 1 while the over-temperature warning is active (`otw_n` low, registered once).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pulse_in | input | 1 | Laser pulse from the generator |
| pulse_cnt | input | CNT_W | Generator counter, 0 to period-1 |
| pulse_period | input | CNT_W | Generator period in cycles |
| otw_n | input | 1 | Over-temperature warning, active low |
| drv_en | output | 1 | Laser driver enable |
| chan_sel | output | 2 | Receive channel select |
| data_clr | output | 1 | One-cycle pre-pulse clear strobe |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the timing of the clear strobe and the rotation step against the pulse counter, and the wrap from entry 3 back to 0, for many offsets and periods. The bench acts as the pulse generator. It sweeps several offsets and two periods over five full periods each, and for every cycle it computes in its own model where the strobe should be and which rotation entry should show. Before each configuration the sequencer is disabled and re-enabled, which also exercises the return to entry 0.

// File: rtl/pulse_seq_ctrl.sv
module pulse_seq_ctrl #(
  parameter int CNT_W      = 16,
  parameter int OFFSET_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic [CNT_W-1:0] pulse_period,
  input  logic             otw_n,
  output logic             drv_en,
  output logic [1:0]       chan_sel,
  output logic             data_clr,
  output logic             irq
);

  localparam logic [3:0] W_DRV  = 4'd0;
  localparam logic [3:0] W_OTW  = 4'd1;
  localparam logic [3:0] W_MASK = 4'd2;
  localparam logic [3:0] W_SRC  = 4'd3;
  localparam logic [3:0] W_PEND = 4'd4;
  localparam logic [3:0] W_CTRL = 4'd5;
  localparam logic [3:0] W_OFF  = 4'd6;
  localparam logic [3:0] W_ROT  = 4'd7;
  localparam logic [3:0] W_MAN  = 4'd8;
  localparam int         PADW   = 32 - CNT_W;

  logic             drv_q, otw_q, seq_en, seq_auto, clr_q;
  logic [2:0]       mask_q, src_q, events, w1c;
  logic [CNT_W-1:0] off_q, step_at, clr_at;
  logic [7:0]       rot_q;
  logic [1:0]       man_q, idx_q;

  assign step_at = pulse_period - off_q;
  assign clr_at  = step_at - CNT_W'(2);
  assign events  = {otw_n & ~otw_q, ~otw_n & otw_q, pulse_in};
  assign w1c     = (reg_wr && (reg_addr == W_SRC || reg_addr == W_PEND)) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q    <= 1'b0;
      otw_q    <= 1'b1;
      mask_q   <= 3'b111;
      src_q    <= 3'b000;
      seq_en   <= 1'b0;
      seq_auto <= 1'b0;
      off_q    <= CNT_W'(OFFSET_RST);
      rot_q    <= '0;
      man_q    <= '0;
      idx_q    <= '0;
      clr_q    <= 1'b0;
    end else begin
      otw_q <= otw_n;
      src_q <= (src_q & ~w1c) | events;
      clr_q <= (pulse_cnt == clr_at);
      if (reg_wr) begin
        case (reg_addr)
          W_DRV:  drv_q  <= reg_wdata[0];
          W_MASK: mask_q <= reg_wdata[2:0];
          W_CTRL: {seq_auto, seq_en} <= reg_wdata[1:0];
          W_OFF:  off_q  <= reg_wdata[CNT_W-1:0];
          W_ROT:  rot_q  <= {reg_wdata[13:12], reg_wdata[9:8], reg_wdata[5:4], reg_wdata[1:0]};
          W_MAN:  man_q  <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (!seq_en)
        idx_q <= '0;
      else if (seq_auto && pulse_cnt == step_at)
        idx_q <= idx_q + 2'd1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      W_DRV:  reg_rdata[0]   = drv_q;
      W_OTW:  reg_rdata[0]   = ~otw_q;
      W_MASK: reg_rdata[2:0] = mask_q;
      W_SRC:  reg_rdata[2:0] = src_q;
      W_PEND: reg_rdata[2:0] = src_q & ~mask_q;
      W_CTRL: reg_rdata[1:0] = {seq_auto, seq_en};
      W_OFF:  reg_rdata      = {{PADW{1'b0}}, off_q};
      W_ROT:  reg_rdata      = {18'd0, rot_q[7:6], 2'd0, rot_q[5:4], 2'd0, rot_q[3:2], 2'd0, rot_q[1:0]};
      W_MAN:  reg_rdata[1:0] = man_q;
      default: ;
    endcase
  end

  assign drv_en   = drv_q;
  assign data_clr = clr_q;
  assign irq      = |(src_q & ~mask_q);
  assign chan_sel = !seq_en ? 2'b00 : (seq_auto ? rot_q[2*idx_q +: 2] : man_q);

endmodule

// File: rtl/pulse_seq_ctrl_chk.sv
module pulse_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse_in,
  input logic       otw_n,
  input logic       irq,
  input logic [1:0] chan_sel,
  input logic       seq_en,
  input logic       seq_auto,
  input logic [1:0] man_q,
  input logic [1:0] idx_q,
  input logic [2:0] src_q,
  input logic [2:0] mask_q
);

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_en |-> chan_sel == 2'b00); // R3

  AST_MANUAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !seq_auto) |-> chan_sel == man_q); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> (idx_q == $past(idx_q) + 2'd1 || idx_q == 2'd0)); // R5

  AST_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_in |=> src_q[0]); // R7

  AST_OTW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(otw_n) |=> src_q[1]); // R7

  AST_OTW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otw_n) |=> src_q[2]); // R7

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & ~mask_q) == 3'b000) |-> !irq); // R8

endmodule

bind pulse_seq_ctrl pulse_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .otw_n(otw_n), .irq(irq),
  .chan_sel(chan_sel), .seq_en(seq_en), .seq_auto(seq_auto), .man_q(man_q),
  .idx_q(idx_q), .src_q(src_q), .mask_q(mask_q)
);

// File: tb/test_pulse_seq_ctrl.sv
module test_pulse_seq_ctrl;
  localparam int CNT_W = 16;
  localparam int OFFSET_RST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pulse_in = 1'b0;
  logic [CNT_W-1:0] pulse_cnt = '0;
  logic [CNT_W-1:0] pulse_period = CNT_W'(8);
  logic otw_n = 1'b1;
  logic drv_en, data_clr, irq;
  logic [1:0] chan_sel;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pulse_seq_ctrl #(.CNT_W(CNT_W), .OFFSET_RST(OFFSET_RST)) i_pulse_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_in(pulse_in),
    .pulse_cnt(pulse_cnt), .pulse_period(pulse_period), .otw_n(otw_n),
    .drv_en(drv_en), .chan_sel(chan_sel), .data_clr(data_clr), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [1:0] ent [4];
    int exp_idx;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 drv_en", drv_en, 0);
    chk("R1 chan_sel", chan_sel, 0);
    chk("R1 irq", irq, 0);
    rd(4'd2, v); chk("R1 mask", v, 7);
    rd(4'd6, v); chk("R1 offset", v, OFFSET_RST);
    rd(4'd3, v); chk("R1 source", v, 0);

    // R2 driver enable
    wr(4'd0, 32'h1); chk("R2 drv on", drv_en, 1);
    wr(4'd0, 32'h2); chk("R2 drv off", drv_en, 0);

    // R3 disabled, R4 manual sweep
    wr(4'd8, 32'h3);
    chk("R3 disabled chan", chan_sel, 0);
    wr(4'd5, 32'h1);
    for (int m = 0; m < 4; m++) begin
      wr(4'd8, 32'(m));
      chk("R4 manual", chan_sel, m);
    end

    // R5 R6 auto sweep
    for (int p = 0; p < 2; p++) begin
      for (int off = 2; off < 6; off++) begin
        int per;
        logic [31:0] rot;
        per = (p == 0) ? 8 : 12;
        rot = (p == 0) ? 32'h3120 : 32'h0213;
        for (int i = 0; i < 4; i++) ent[i] = rot[4*i +: 2];
        pulse_period = CNT_W'(per);
        pulse_cnt = CNT_W'(per - 1);
        wr(4'd5, 32'h0);
        chk("R3 disabled chan", chan_sel, 0);
        wr(4'd6, 32'(off));
        wr(4'd7, rot);
        wr(4'd5, 32'h3);
        chk("R3 restart at entry 0", chan_sel, ent[0]);
        exp_idx = 0;
        for (int k = 0; k < 5 * per; k++) begin
          int c;
          c = k % per;
          pulse_cnt = CNT_W'(c);
          tick();
          if (c == per - off) exp_idx = (exp_idx + 1) % 4;
          chk("R6 clear strobe", data_clr, (c == per - off - 2) ? 1 : 0);
          chk("R5 auto entry", chan_sel, ent[exp_idx]);
        end
      end
    end
    wr(4'd5, 32'h0);

    // R7 R8 R9 R10 interrupts
    wr(4'd2, 32'h0);
    wr(4'd3, 32'h7);
    chk("R8 irq idle", irq, 0);
    rd(4'd4, v); chk("R8 pending idle", v, 0);
    pulse_in = 1'b1; tick(); pulse_in = 1'b0;
    chk("R8 irq pulse", irq, 1);
    rd(4'd3, v); chk("R7 pulse source", v, 1);
    wr(4'd4, 32'h0);
    rd(4'd3, v); chk("R9 write 0 keeps", v, 1);
    wr(4'd4, 32'h1);
    rd(4'd3, v); chk("R9 pending clear", v, 0);
    chk("R9 irq cleared", irq, 0);
    wr(4'd2, 32'h1);
    pulse_in = 1'b1; tick(); pulse_in = 1'b0;
    rd(4'd3, v); chk("R8 masked source", v, 1);
    rd(4'd4, v); chk("R8 masked pending", v, 0);
    chk("R8 masked irq", irq, 0);
    rd(4'd1, v); chk("R10 no warning", v, 0);
    otw_n = 1'b0; tick();
    rd(4'd3, v); chk("R7 entry source", v, 3);
    chk("R8 entry irq", irq, 1);
    rd(4'd1, v); chk("R10 warning", v, 1);
    wr(4'd3, 32'h3);
    rd(4'd3, v); chk("R9 source clear", v, 0);
    otw_n = 1'b1; tick();
    rd(4'd3, v); chk("R7 exit source", v, 4);
    rd(4'd4, v); chk("R8 exit pending", v, 4);
    rd(4'd1, v); chk("R10 warning gone", v, 0);
    wr(4'd2, 32'h7);
    chk("R8 all masked irq", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule